// File: doc/BRIEF.md
# Boot-Remapping System Address Decoder

This block sits between a processor's byte-addressed bus and the rest of a small system. For every access it takes the byte address, the access width (one, two or four bytes) and the direction. From these it raises exactly one select for RAM, boot ROM or one of ten memory-mapped device windows, and it translates the address into the offset that the selected target expects. Accesses that land nowhere are flagged on a registered error output one cycle later. Writes aimed at the read-only part of the boot ROM are reported on a separate write-protect output.

Four address ranges come from configuration inputs that are held steady while the block runs: a read-only RAM range, a read-write RAM range, a read-only ROM range and a ROM data range. The ROM data range physically lives in RAM. All ranges are half-open, and an access hits a range only if every byte it touches lies inside. Device windows are fixed by parameters. Two wide windows have even bases. Eight narrow windows have odd bases and carry a single byte lane, so their offset is halved.

After reset the block is armed for the boot vector sequence. A 32-bit read of address 0 or 4 is moved up by the ROM base, so both start vectors come from ROM. The read of address 4 disarms the remap until the next reset.

Top module: `sys_addr_decoder`

## Requirements
- R1: RAM selects carry the absolute address as offset (RAM base 0). The read-only ROM range selects ROM with offset = address − 0x100000.
- R2: After reset the remap is armed (`boot_remap_o`=1). While armed, a 32-bit read of address 0 or 4 is decoded as address+0x100000. The read of address 4 clears `boot_remap_o` at the next clock edge.
- R3: While armed, a 32-bit read of any other address selects nothing and raises the error. Once disarmed, the remap stays off until reset. Accesses that are not 32-bit reads are never remapped.
- R4: Device windows are half-open. Window 0 is [0x180000,0x200000) and window 1 is [0x200000,0x280000). Windows 2..9 are 0x4000 bytes each and run back to back from 0x3A0001 to 0x3C0001. `sel_dev_o[i]` selects window i.
- R5: In a window with an even base, offset = address − base. In a window with an odd base, offset = (address − base) / 2.
- R6: The regions are tried in a fixed order and the first hit wins: RAM read-only, RAM read-write, ROM read-only, ROM data, device windows, then the low region [0, 0x10000).
- R7: An access of n bytes hits a range [lo,hi) only if lo ≤ address and address + n ≤ hi.
- R8: The read-only RAM and ROM ranges ignore writes, and decode falls through to the later regions. `rom_wp_o` is 1 for a write that lies inside the read-only ROM range.
- R9: An access in the ROM data range selects RAM, with the absolute address as offset.
- R10: A valid access that selects nothing sets `err_o` for the cycle after it. A valid access that selects a target leaves `err_o` at 0. With nothing selected the offset is 0. At most one select is active.
- R11: `req_size_i` codes are 0 = byte, 1 = two bytes, 2 = four bytes and 3 = illegal. An illegal size selects nothing and raises the error. With `req_valid_i` low, nothing is selected and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Access present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | Access width code |
| req_addr_i | input | 24 | Byte address |
| ram_ro_lo_i | input | 24 | Read-only RAM range start |
| ram_ro_hi_i | input | 24 | Read-only RAM range end (exclusive) |
| ram_rw_lo_i | input | 24 | Read-write RAM range start |
| ram_rw_hi_i | input | 24 | Read-write RAM range end (exclusive) |
| rom_ro_lo_i | input | 24 | Read-only ROM range start |
| rom_ro_hi_i | input | 24 | Read-only ROM range end (exclusive) |
| bss_lo_i | input | 24 | ROM data range start |
| bss_hi_i | input | 24 | ROM data range end (exclusive) |
| sel_ram_o | output | 1 | RAM selected |
| sel_rom_o | output | 1 | Boot ROM selected |
| sel_dev_o | output | 10 | One select per device window |
| local_off_o | output | 24 | Offset within the selected target |
| rom_wp_o | output | 1 | Write refused by the read-only ROM range |
| boot_remap_o | output | 1 | Boot vector remap armed |
| err_o | output | 1 | Previous cycle's access was illegal |

## Verification
The assertions check on every cycle that at most one select is active and that a write refused by ROM never selects ROM. They also check that `err_o` follows, one cycle later, whether the previous access found a target, and that a window's offset stays inside that window's span. The armed flag is checked as well: the fetch of address 4 must clear it, and once clear it must stay clear. Only the bench scenarios can show that the decode order is right where ranges overlap, and that the boundary arithmetic for multi-byte accesses is exact. The same holds for the halved offsets in odd-based windows and for the full boot sequence across two resets.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  // Number of bytes an access touches; the illegal code is treated as four.
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  // Base of device window idx: wide windows first, then narrow ones.
  function automatic logic [31:0] win_base(input int idx, input int wide_cnt,
                                           input logic [31:0] wide_base,
                                           input logic [31:0] wide_span,
                                           input logic [31:0] narrow_base,
                                           input logic [31:0] narrow_span);
    if (idx < wide_cnt)
      win_base = wide_base + 32'(idx) * wide_span;
    else
      win_base = narrow_base + 32'(idx - wide_cnt) * narrow_span;
  endfunction

endpackage

// File: rtl/range_match.sv
module range_match #(
  parameter int AW = 24
) (
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    nbytes_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  output logic          hit_o
);
  logic [AW:0] end_excl;

  always_comb begin
    // One bit of headroom so the end of the access never wraps.
    end_excl = {1'b0, addr_i} + (AW+1)'(nbytes_i);
    hit_o    = (addr_i >= lo_i) && (end_excl <= {1'b0, hi_i});
  end
endmodule

// File: rtl/dev_window.sv
module dev_window #(
  parameter int          AW   = 24,
  parameter logic [31:0] BASE = 32'h0018_0000,
  parameter logic [31:0] SPAN = 32'h0008_0000
) (
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    nbytes_i,
  output logic          hit_o,
  output logic [AW-1:0] off_o
);
  localparam logic [AW-1:0] LO = BASE[AW-1:0];
  localparam logic [31:0]   HI_FULL = BASE + SPAN;
  localparam logic [AW-1:0] HI = HI_FULL[AW-1:0];

  logic [AW-1:0] rel;

  range_match #(.AW(AW)) u_rng (
    .addr_i   (addr_i),
    .nbytes_i (nbytes_i),
    .lo_i     (LO),
    .hi_i     (HI),
    .hit_o    (hit_o)
  );

  assign rel = addr_i - LO;

  generate
    if (BASE[0]) begin : g_byte_lane
      // Odd base: device sits on one byte lane, every other address.
      assign off_o = rel >> 1;
    end else begin : g_full_bus
      assign off_o = rel;
    end
  endgenerate
endmodule

// File: rtl/vector_remap.sv
module vector_remap
  import addr_dec_pkg::*;
#(
  parameter int          AW       = 24,
  parameter logic [31:0] ROM_BASE = 32'h0010_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          write_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] eff_addr_o,
  output logic          bad_seq_o,
  output logic          armed_o
);
  localparam logic [AW-1:0] ROM_OFS   = ROM_BASE[AW-1:0];
  localparam logic [AW-1:0] VEC_FIRST = '0;
  localparam logic [AW-1:0] VEC_LAST  = AW'(4);

  logic armed_q, armed_d;
  logic word_rd, is_first, is_last;

  always_comb begin
    word_rd  = valid_i && !write_i && (size_i == SZ_WORD);
    is_first = (addr_i == VEC_FIRST);
    is_last  = (addr_i == VEC_LAST);

    armed_d = armed_q;
    if (armed_q && word_rd && is_last) armed_d = 1'b0;

    eff_addr_o = addr_i;
    if (armed_q && word_rd && (is_first || is_last)) eff_addr_o = addr_i + ROM_OFS;

    bad_seq_o = armed_q && word_rd && !(is_first || is_last);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b1;
    else         armed_q <= armed_d;
  end

  assign armed_o = armed_q;

  // R2: the second vector fetch disarms the remap.
  p_disarm_on_vec4_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && valid_i && !write_i && size_i == SZ_WORD && addr_i == VEC_LAST) |=> !armed_q);

  // R3: once disarmed, the remap stays off until reset.
  p_stays_disarmed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> !armed_q);

  // R3: no address translation while disarmed.
  p_no_remap_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> (eff_addr_o == addr_i));
endmodule

// File: rtl/sys_addr_decoder.sv
module sys_addr_decoder
  import addr_dec_pkg::*;
#(
  parameter int          AW          = 24,
  parameter logic [31:0] RAM_BASE    = 32'h0000_0000,
  parameter logic [31:0] ROM_BASE    = 32'h0010_0000,
  parameter logic [31:0] LOW_LIMIT   = 32'h0001_0000,
  parameter int          WIDE_CNT    = 2,
  parameter logic [31:0] WIDE_BASE   = 32'h0018_0000,
  parameter logic [31:0] WIDE_SPAN   = 32'h0008_0000,
  parameter int          NARROW_CNT  = 8,
  parameter logic [31:0] NARROW_BASE = 32'h003A_0001,
  parameter logic [31:0] NARROW_SPAN = 32'h0000_4000,
  localparam int         NDEV        = WIDE_CNT + NARROW_CNT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic            req_write_i,
  input  logic [1:0]      req_size_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [AW-1:0]   ram_ro_lo_i,
  input  logic [AW-1:0]   ram_ro_hi_i,
  input  logic [AW-1:0]   ram_rw_lo_i,
  input  logic [AW-1:0]   ram_rw_hi_i,
  input  logic [AW-1:0]   rom_ro_lo_i,
  input  logic [AW-1:0]   rom_ro_hi_i,
  input  logic [AW-1:0]   bss_lo_i,
  input  logic [AW-1:0]   bss_hi_i,
  output logic            sel_ram_o,
  output logic            sel_rom_o,
  output logic [NDEV-1:0] sel_dev_o,
  output logic [AW-1:0]   local_off_o,
  output logic            rom_wp_o,
  output logic            boot_remap_o,
  output logic            err_o
);
  localparam logic [AW-1:0] RAM_OFS = RAM_BASE[AW-1:0];
  localparam logic [AW-1:0] ROM_OFS = ROM_BASE[AW-1:0];
  localparam logic [AW-1:0] LOW_HI  = LOW_LIMIT[AW-1:0];
  localparam int            NRANGE  = 4;
  localparam int            IDX_RAM_RO = 0;
  localparam int            IDX_RAM_RW = 1;
  localparam int            IDX_ROM_RO = 2;
  localparam int            IDX_BSS    = 3;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Boot vector remap
  logic [AW-1:0] eff_addr;
  logic          bad_seq;

  vector_remap #(.AW(AW), .ROM_BASE(ROM_BASE)) u_remap (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .valid_i    (req_valid_i),
    .write_i    (req_write_i),
    .size_i     (req_size_i),
    .addr_i     (req_addr_i),
    .eff_addr_o (eff_addr),
    .bad_seq_o  (bad_seq),
    .armed_o    (boot_remap_o)
  );

  logic [2:0] nbytes;
  logic       bad_size;
  assign nbytes   = size_bytes(req_size_i);
  assign bad_size = (req_size_i == SZ_BAD);

  // Programmable ranges
  logic [AW-1:0]     rng_lo [NRANGE];
  logic [AW-1:0]     rng_hi [NRANGE];
  logic [NRANGE-1:0] rng_hit;

  assign rng_lo[IDX_RAM_RO] = ram_ro_lo_i;
  assign rng_hi[IDX_RAM_RO] = ram_ro_hi_i;
  assign rng_lo[IDX_RAM_RW] = ram_rw_lo_i;
  assign rng_hi[IDX_RAM_RW] = ram_rw_hi_i;
  assign rng_lo[IDX_ROM_RO] = rom_ro_lo_i;
  assign rng_hi[IDX_ROM_RO] = rom_ro_hi_i;
  assign rng_lo[IDX_BSS]    = bss_lo_i;
  assign rng_hi[IDX_BSS]    = bss_hi_i;

  generate
    for (genvar r = 0; r < NRANGE; r++) begin : g_rng
      range_match #(.AW(AW)) u_rm (
        .addr_i   (eff_addr),
        .nbytes_i (nbytes),
        .lo_i     (rng_lo[r]),
        .hi_i     (rng_hi[r]),
        .hit_o    (rng_hit[r])
      );
    end
  endgenerate

  logic low_hit;
  range_match #(.AW(AW)) u_low (
    .addr_i   (eff_addr),
    .nbytes_i (nbytes),
    .lo_i     ('0),
    .hi_i     (LOW_HI),
    .hit_o    (low_hit)
  );

  // Fixed device windows
  logic [NDEV-1:0] dev_hit;
  logic [AW-1:0]   dev_off [NDEV];

  generate
    for (genvar d = 0; d < NDEV; d++) begin : g_dev
      localparam logic [31:0] W_BASE =
        win_base(d, WIDE_CNT, WIDE_BASE, WIDE_SPAN, NARROW_BASE, NARROW_SPAN);
      localparam logic [31:0] W_SPAN = (d < WIDE_CNT) ? WIDE_SPAN : NARROW_SPAN;
      localparam logic [31:0] W_LIM  = W_BASE[0] ? (W_SPAN >> 1) : W_SPAN;

      dev_window #(.AW(AW), .BASE(W_BASE), .SPAN(W_SPAN)) u_win (
        .addr_i   (eff_addr),
        .nbytes_i (nbytes),
        .hit_o    (dev_hit[d]),
        .off_o    (dev_off[d])
      );

      // R5: a window's offset never leaves its (possibly halved) span.
      p_dev_off_in_span_r5: assert property (@(posedge clk_i) disable iff (!rst_int_n)
        sel_dev_o[d] |-> ({8'h00, local_off_o} < W_LIM));
    end
  endgenerate

  // Priority decode
  logic            dec_go;
  logic            wr;
  logic            sel_ram_d, sel_rom_d;
  logic [NDEV-1:0] sel_dev_d;
  logic [AW-1:0]   off_d;
  logic            dev_found;
  logic            err_d, err_q;

  always_comb begin
    dec_go    = req_valid_i && !bad_size && !bad_seq;
    wr        = req_write_i;
    sel_ram_d = 1'b0;
    sel_rom_d = 1'b0;
    sel_dev_d = '0;
    off_d     = '0;
    dev_found = 1'b0;

    if (dec_go) begin
      if (!wr && rng_hit[IDX_RAM_RO]) begin
        sel_ram_d = 1'b1;
        off_d     = eff_addr - RAM_OFS;
      end else if (rng_hit[IDX_RAM_RW]) begin
        sel_ram_d = 1'b1;
        off_d     = eff_addr - RAM_OFS;
      end else if (!wr && rng_hit[IDX_ROM_RO]) begin
        sel_rom_d = 1'b1;
        off_d     = eff_addr - ROM_OFS;
      end else if (rng_hit[IDX_BSS]) begin
        sel_ram_d = 1'b1;
        off_d     = eff_addr - RAM_OFS;
      end else if (|dev_hit) begin
        for (int i = 0; i < NDEV; i++) begin
          if (dev_hit[i] && !dev_found) begin
            sel_dev_d[i] = 1'b1;
            off_d        = dev_off[i];
            dev_found    = 1'b1;
          end
        end
      end else if (low_hit) begin
        sel_ram_d = 1'b1;
        off_d     = eff_addr;
      end
    end

    err_d = req_valid_i && !(sel_ram_d || sel_rom_d || (|sel_dev_d));
  end

  assign sel_ram_o   = sel_ram_d;
  assign sel_rom_o   = sel_rom_d;
  assign sel_dev_o   = sel_dev_d;
  assign local_off_o = off_d;
  assign rom_wp_o    = req_valid_i && req_write_i && !bad_size && rng_hit[IDX_ROM_RO];

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) err_q <= 1'b0;
    else            err_q <= err_d;
  end
  assign err_o = err_q;

  // R10: never more than one target.
  p_onehot_sel_r10: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    $onehot0({sel_ram_o, sel_rom_o, sel_dev_o}));

  // R10: an access that found no target is flagged on the next cycle.
  p_err_on_miss_r10: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (req_valid_i && !(sel_ram_o || sel_rom_o || (|sel_dev_o))) |=> err_o);

  // R10: an access that found a target is never flagged.
  p_no_err_on_hit_r10: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (sel_ram_o || sel_rom_o || (|sel_dev_o)) |=> !err_o);

  // R8: a refused ROM write never reaches ROM.
  p_wp_blocks_rom_r8: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    rom_wp_o |-> !sel_rom_o);
endmodule

// File: tb/sys_addr_decoder_bench.sv
module sys_addr_decoder_bench;
  localparam int AW   = 24;
  localparam int NDEV = 10;

  logic            clk, rst_n;
  logic            valid, write;
  logic [1:0]      size;
  logic [AW-1:0]   addr;
  logic [AW-1:0]   ram_ro_lo, ram_ro_hi, ram_rw_lo, ram_rw_hi;
  logic [AW-1:0]   rom_ro_lo, rom_ro_hi, bss_lo, bss_hi;
  logic            sel_ram, sel_rom, rom_wp, boot_remap, err;
  logic [NDEV-1:0] sel_dev;
  logic [AW-1:0]   off;

  int n_chk = 0;
  int n_bad = 0;

  sys_addr_decoder u_sys_addr_decoder (
    .clk_i (clk), .rst_ni (rst_n),
    .req_valid_i (valid), .req_write_i (write), .req_size_i (size), .req_addr_i (addr),
    .ram_ro_lo_i (ram_ro_lo), .ram_ro_hi_i (ram_ro_hi),
    .ram_rw_lo_i (ram_rw_lo), .ram_rw_hi_i (ram_rw_hi),
    .rom_ro_lo_i (rom_ro_lo), .rom_ro_hi_i (rom_ro_hi),
    .bss_lo_i (bss_lo), .bss_hi_i (bss_hi),
    .sel_ram_o (sel_ram), .sel_rom_o (sel_rom), .sel_dev_o (sel_dev),
    .local_off_o (off), .rom_wp_o (rom_wp), .boot_remap_o (boot_remap), .err_o (err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // sel: bit 11 RAM, bit 10 ROM, bits 9..0 device windows
  typedef struct packed {
    logic        v;
    logic        w;
    logic [1:0]  sz;
    logic [23:0] a;
    logic [11:0] sel;
    logic [23:0] off;
    logic        err;
    logic        wp;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 2'd2, 24'h010000, 12'h800, 24'h010000, 1'b0, 1'b0}, // R1 ram ro
    '{1'b1, 1'b0, 2'd2, 24'h01FFFC, 12'h800, 24'h01FFFC, 1'b0, 1'b0}, // R7 last fits
    '{1'b1, 1'b0, 2'd2, 24'h01FFFE, 12'h000, 24'h000000, 1'b1, 1'b0}, // R7 straddles
    '{1'b1, 1'b1, 2'd1, 24'h010000, 12'h000, 24'h000000, 1'b1, 1'b0}, // R8 ram ro write
    '{1'b1, 1'b1, 2'd0, 24'h030000, 12'h800, 24'h030000, 1'b0, 1'b0}, // R1 ram rw
    '{1'b1, 1'b0, 2'd0, 24'h100004, 12'h400, 24'h000004, 1'b0, 1'b0}, // R1 rom ro
    '{1'b1, 1'b1, 2'd0, 24'h100004, 12'h000, 24'h000000, 1'b1, 1'b1}, // R8 rom write
    '{1'b1, 1'b0, 2'd2, 24'h0F0010, 12'h800, 24'h0F0010, 1'b0, 1'b0}, // R9 bss read
    '{1'b1, 1'b1, 2'd1, 24'h0F7FFE, 12'h800, 24'h0F7FFE, 1'b0, 1'b0}, // R9 bss write edge
    '{1'b1, 1'b0, 2'd1, 24'h180010, 12'h001, 24'h000010, 1'b0, 1'b0}, // R4 window 0
    '{1'b1, 1'b1, 2'd2, 24'h27FFFC, 12'h002, 24'h07FFFC, 1'b0, 1'b0}, // R4 window 1 top
    '{1'b1, 1'b0, 2'd1, 24'h27FFFF, 12'h000, 24'h000000, 1'b1, 1'b0}, // R7 window 1 spill
    '{1'b1, 1'b0, 2'd0, 24'h3A0001, 12'h004, 24'h000000, 1'b0, 1'b0}, // R4 window 2 base
    '{1'b1, 1'b0, 2'd0, 24'h3A4005, 12'h008, 24'h000002, 1'b0, 1'b0}, // R5 halved
    '{1'b1, 1'b1, 2'd0, 24'h3C0000, 12'h200, 24'h001FFF, 1'b0, 1'b0}, // R5 window 9 top
    '{1'b1, 1'b0, 2'd0, 24'h3C0001, 12'h000, 24'h000000, 1'b1, 1'b0}, // R4 past last
    '{1'b1, 1'b0, 2'd2, 24'h3A8001, 12'h010, 24'h000000, 1'b0, 1'b0}, // R4 window 4
    '{1'b1, 1'b0, 2'd0, 24'h00FFFF, 12'h800, 24'h00FFFF, 1'b0, 1'b0}, // R6 low region
    '{1'b1, 1'b0, 2'd2, 24'h00FFFD, 12'h000, 24'h000000, 1'b1, 1'b0}, // R7 low spill
    '{1'b1, 1'b0, 2'd3, 24'h000100, 12'h000, 24'h000000, 1'b1, 1'b0}, // R11 bad size
    '{1'b0, 1'b0, 2'd2, 24'h010000, 12'h000, 24'h000000, 1'b0, 1'b0}  // R11 idle
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, check decode mid-cycle, check error after the rising edge.
  task automatic access(input string req, input logic v, input logic w, input logic [1:0] sz,
                        input logic [23:0] a, input logic [11:0] esel, input logic [23:0] eoff,
                        input logic eerr, input logic ewp);
    @(negedge clk);
    valid = v; write = w; size = sz; addr = a;
    #2;
    chk({req, " select"}, 32'({sel_ram, sel_rom, sel_dev}), 32'(esel));
    chk({req, " offset"}, 32'(off), 32'(eoff));
    chk({req, " write-protect"}, 32'(rom_wp), 32'(ewp));
    @(posedge clk);
    #1;
    chk({req, " error"}, 32'(err), 32'(eerr));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; valid = 1'b0; write = 1'b0; size = 2'd0; addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; valid = 1'b0; write = 1'b0; size = 2'd0; addr = '0;
    ram_ro_lo = 24'h010000; ram_ro_hi = 24'h020000;
    ram_rw_lo = 24'h020000; ram_rw_hi = 24'h040000;
    rom_ro_lo = 24'h100000; rom_ro_hi = 24'h108000;
    bss_lo    = 24'h0F0000; bss_hi    = 24'h0F8000;
    do_reset();

    // Reset state (R2, R10)
    #1;
    chk("R2 armed after reset", 32'(boot_remap), 32'd1);
    chk("R10 no error after reset", 32'(err), 32'd0);
    chk("R11 idle selects nothing", 32'({sel_ram, sel_rom, sel_dev}), 32'd0);

    // Boot vector sequence (R2, R3)
    access("R2 vector 0", 1, 0, 2'd2, 24'h000000, 12'h400, 24'h000000, 0, 0);
    chk("R2 still armed after vector 0", 32'(boot_remap), 32'd1);
    access("R3 byte read not remapped", 1, 0, 2'd0, 24'h000100, 12'h800, 24'h000100, 0, 0);
    access("R3 write not remapped", 1, 1, 2'd2, 24'h000000, 12'h800, 24'h000000, 0, 0);
    access("R2 vector 4", 1, 0, 2'd2, 24'h000004, 12'h400, 24'h000004, 0, 0);
    chk("R2 disarmed after vector 4", 32'(boot_remap), 32'd0);
    access("R3 no remap once disarmed", 1, 0, 2'd2, 24'h000000, 12'h800, 24'h000000, 0, 0);
    access("R3 vector 4 again not remapped", 1, 0, 2'd2, 24'h000004, 12'h800, 24'h000004, 0, 0);
    chk("R3 stays disarmed", 32'(boot_remap), 32'd0);

    // Bad sequence after a second reset
    do_reset();
    #1;
    chk("R2 re-armed by reset", 32'(boot_remap), 32'd1);
    access("R3 bad vector fetch", 1, 0, 2'd2, 24'h000008, 12'h000, 24'h000000, 1, 0);
    chk("R3 still armed after bad fetch", 32'(boot_remap), 32'd1);
    access("R2 vector 4 after bad", 1, 0, 2'd2, 24'h000004, 12'h400, 24'h000004, 0, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      access($sformatf("vector %0d", i), VEC[i].v, VEC[i].w, VEC[i].sz, VEC[i].a,
             VEC[i].sel, VEC[i].off, VEC[i].err, VEC[i].wp);
    end

    // R6/R8: ROM data range overlapping the read-only ROM range
    @(negedge clk);
    bss_lo = 24'h100000; bss_hi = 24'h100100;
    access("R6 rom ro wins on read", 1, 0, 2'd0, 24'h100010, 12'h400, 24'h000010, 0, 0);
    access("R8 write falls to data range", 1, 1, 2'd0, 24'h100010, 12'h800, 24'h100010, 0, 1);
    // R6: RAM read-write range ahead of the low region
    @(negedge clk);
    ram_rw_lo = 24'h000000; ram_rw_hi = 24'h000100;
    access("R6 ram rw before low", 1, 1, 2'd2, 24'h0000FC, 12'h800, 24'h0000FC, 0, 0);

    @(negedge clk);
    valid = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule